// File: doc/BRIEF.md
# Multiword Variable-Precision Floating-Point Multiplier

This block multiplies two floating-point operands whose significands are made of a variable number of 8-bit words. Each operand arrives as a sign bit, a 2-bit class code, a 5-bit word-count field, a 16-bit exponent and a packed significand. A one-cycle `start` pulse, sampled while the block is idle, captures both operands. The sign, exponent, result class and length are worked out at once. The significand product is then built one word pair per cycle with a single 8×8 multiplier. Each 16-bit partial product is added into the result accumulator as soon as it exists, so no partial products are stored.

If either operand is not a normal number, the block skips the word loop and finishes in one cycle. Otherwise the controller walks the operand words and returns the exact, unrounded product. `done` is high for one cycle once the result is ready. The result fields hold their values until the next accepted `start`. Normalization, rounding and exponent range checks are left to the block that uses this one.

The controller has three states:
- **IDLE**: waits for `start`.
- **MULT**: one accumulation per cycle.
- **DONE**: the cycle in which `done` is high.

The transitions are:
- **accept-normal**: IDLE to MULT, taken on `start` when both operands are normal.
- **accept-special**: IDLE to DONE, taken on `start` when either operand is a special class.
- **step**: MULT to MULT, taken while word pairs remain.
- **last-step**: MULT to DONE, taken on the final word pair.
- **release**: DONE to IDLE, taken unconditionally.

Top module: `vpfp_mul`

## Requirements
- R1: `r_sign` is the XOR of `a_sign` and `b_sign`, for every operand class.
- R2: `r_exp` is the sum of `a_exp` and `b_exp` as 16-bit two's-complement values, wrapping modulo 2^16, for every operand class.
- R3: `r_len` is the raw sum of `a_len` and `b_len`. When that sum exceeds 31, `r_len` is 31 and `r_len_ovf` is 1; otherwise `r_len_ovf` is 0. A sum of exactly 31 is not an overflow.
- R4: Class codes are 0 normal, 1 zero, 2 infinite, 3 NaN. The result class is resolved as follows:
  - NaN on either input gives NaN.
  - Infinite times zero, in either order, gives NaN.
  - Otherwise, infinite on either input gives infinite.
  - Otherwise, zero on either input gives zero.
  - Otherwise, the result is normal.
- R5: Operand significand word k sits at bits [8k+7:8k] of `a_sig`/`b_sig`. Word 0 is the most significant, and only the first n words count. For two normal operands, result word k sits at bits [8k+7:8k] of `r_sig`. Word 0 is the most significant, and words 0..na+nb-1 hold the exact product.
- R6: For two normal operands, `done` is high in exactly one cycle, na·nb+1 cycles after the edge that accepted `start`.
- R7: For a special result, `done` is high in the cycle right after the accepting edge, and `r_sig` is all zero.
- R8: `busy` is high from the cycle after the accepting edge through the `done` cycle, and low otherwise. A `start` seen while `busy` is high changes nothing.
- R9: The effective word count n of an operand is its length field, clamped to the range 1..8. A field of 0 uses one word.
- R10: Result words at positions na+nb and above are zero, and unused operand input words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture both operands (while idle) |
| a_sign | input | 1 | Operand A sign |
| a_type | input | 2 | Operand A class code |
| a_len | input | 5 | Operand A word-count field |
| a_exp | input | 16 | Operand A exponent |
| a_sig | input | 64 | Operand A significand words, word 0 in bits 7:0 |
| b_sign | input | 1 | Operand B sign |
| b_type | input | 2 | Operand B class code |
| b_len | input | 5 | Operand B word-count field |
| b_exp | input | 16 | Operand B exponent |
| b_sig | input | 64 | Operand B significand words, word 0 in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| r_sign | output | 1 | Result sign |
| r_type | output | 2 | Result class code |
| r_len | output | 5 | Result word-count field (saturated) |
| r_len_ovf | output | 1 | Length sum exceeded 31 |
| r_exp | output | 16 | Result exponent |
| r_sig | output | 128 | Result significand words, word 0 in bits 7:0 |

## Verification
A wrong word index or a lost carry in the accumulator shows up only at the `done` cycle. It appears as a result word that differs from the exact product. It is most visible with all-ones operands, where carries run across every word. A wrong loop bound or a stray transition in the controller moves the `done` pulse or the `busy` window by at least one cycle. Because the bench predicts both signals on every clock, such a fault is caught in the first wrong cycle. A capture that reacts to `start` while busy corrupts the exponent or length fields, and this is visible at the end of the same operation.

// File: rtl/vpfp_pkg.sv
package vpfp_pkg;
    typedef enum logic [1:0] {
        CL_NORM = 2'd0,
        CL_ZERO = 2'd1,
        CL_INF  = 2'd2,
        CL_NAN  = 2'd3
    } vclass_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MULT = 2'd1,
        S_DONE = 2'd2
    } vstate_e;
endpackage

// File: rtl/vpfp_class.sv
module vpfp_class
    import vpfp_pkg::*;
(
    input  logic [1:0] a_cls,
    input  logic [1:0] b_cls,
    output logic [1:0] r_cls,
    output logic       special
);
    vclass_e ca, cb, cr;

    always_comb begin
        ca = vclass_e'(a_cls);
        cb = vclass_e'(b_cls);
        if (ca == CL_NAN || cb == CL_NAN)
            cr = CL_NAN;
        else if ((ca == CL_INF && cb == CL_ZERO) || (ca == CL_ZERO && cb == CL_INF))
            cr = CL_NAN;
        else if (ca == CL_INF || cb == CL_INF)
            cr = CL_INF;
        else if (ca == CL_ZERO || cb == CL_ZERO)
            cr = CL_ZERO;
        else
            cr = CL_NORM;
        r_cls   = cr;
        special = (cr != CL_NORM);
    end
endmodule

// File: rtl/vpfp_wordmac.sv
module vpfp_wordmac #(
    parameter int WORD_W = 8,
    parameter int ACC_W  = 128,
    parameter int POS_W  = 4
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [POS_W-1:0]  pos,
    output logic [ACC_W-1:0]  acc_nx
);
    logic [2*WORD_W-1:0] prod;
    logic [ACC_W-1:0]    placed;

    always_comb begin
        prod   = a_word * b_word;
        placed = ACC_W'(prod) << (int'(pos) * WORD_W);
        acc_nx = acc + placed;
    end
endmodule

// File: rtl/vpfp_pack.sv
module vpfp_pack #(
    parameter int WORD_W    = 8,
    parameter int RES_WORDS = 16,
    parameter int TOT_W     = 5
) (
    input  logic [RES_WORDS*WORD_W-1:0] acc,
    input  logic [TOT_W-1:0]            n_tot,
    output logic [RES_WORDS*WORD_W-1:0] sig
);
    always_comb begin
        sig = '0;
        for (int k = 0; k < RES_WORDS; k++) begin
            if (k < int'(n_tot))
                sig[k*WORD_W +: WORD_W] = acc[(int'(n_tot) - 1 - k)*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/vpfp_mul.sv
module vpfp_mul
    import vpfp_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int MAX_WORDS = 8,
    parameter int LEN_W     = 5,
    parameter int EXP_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            a_sign,
    input  logic [1:0]                      a_type,
    input  logic [LEN_W-1:0]                a_len,
    input  logic [EXP_W-1:0]                a_exp,
    input  logic [MAX_WORDS*WORD_W-1:0]     a_sig,
    input  logic                            b_sign,
    input  logic [1:0]                      b_type,
    input  logic [LEN_W-1:0]                b_len,
    input  logic [EXP_W-1:0]                b_exp,
    input  logic [MAX_WORDS*WORD_W-1:0]     b_sig,
    output logic                            busy,
    output logic                            done,
    output logic                            r_sign,
    output logic [1:0]                      r_type,
    output logic [LEN_W-1:0]                r_len,
    output logic                            r_len_ovf,
    output logic [EXP_W-1:0]                r_exp,
    output logic [2*MAX_WORDS*WORD_W-1:0]   r_sig
);
    localparam int RES_WORDS = 2 * MAX_WORDS;
    localparam int ACC_W     = RES_WORDS * WORD_W;
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int POS_W     = $clog2(RES_WORDS);
    localparam int TOT_W     = $clog2(RES_WORDS + 1);

    vstate_e state, state_nx;

    logic [WORD_W-1:0] a_mem [MAX_WORDS];
    logic [WORD_W-1:0] b_mem [MAX_WORDS];
    logic [WORD_W-1:0] a_ld  [MAX_WORDS];
    logic [WORD_W-1:0] b_ld  [MAX_WORDS];
    logic [ACC_W-1:0]  acc, acc_nx;
    logic [CNT_W-1:0]  na_q, nb_q, eff_a, eff_b;
    logic [IDX_W-1:0]  ia, jb;
    logic [1:0]        cls_res;
    logic              cls_special;
    logic [LEN_W:0]    len_sum;
    logic              accept, last_a, last_b;
    logic [POS_W-1:0]  pos;
    logic [TOT_W-1:0]  n_tot;

    function automatic logic [CNT_W-1:0] eff_words(input logic [LEN_W-1:0] l);
        if (l == '0)
            return CNT_W'(1);
        else if (l > LEN_W'(MAX_WORDS))
            return CNT_W'(MAX_WORDS);
        else
            return CNT_W'(l);
    endfunction

    vpfp_class u_class (
        .a_cls   (a_type),
        .b_cls   (b_type),
        .r_cls   (cls_res),
        .special (cls_special)
    );

    always_comb begin
        eff_a   = eff_words(a_len);
        eff_b   = eff_words(b_len);
        len_sum = {1'b0, a_len} + {1'b0, b_len};
        accept  = (state == S_IDLE) && start;
        last_a  = (CNT_W'(ia) + CNT_W'(1)) == na_q;
        last_b  = (CNT_W'(jb) + CNT_W'(1)) == nb_q;
        pos     = POS_W'(ia) + POS_W'(jb);
        n_tot   = TOT_W'(na_q) + TOT_W'(nb_q);
        for (int i = 0; i < MAX_WORDS; i++) begin
            a_ld[i] = '0;
            b_ld[i] = '0;
            if (i < int'(eff_a))
                a_ld[i] = a_sig[(int'(eff_a) - 1 - i)*WORD_W +: WORD_W];
            if (i < int'(eff_b))
                b_ld[i] = b_sig[(int'(eff_b) - 1 - i)*WORD_W +: WORD_W];
        end
    end

    vpfp_wordmac #(.WORD_W(WORD_W), .ACC_W(ACC_W), .POS_W(POS_W)) u_mac (
        .acc    (acc),
        .a_word (a_mem[ia]),
        .b_word (b_mem[jb]),
        .pos    (pos),
        .acc_nx (acc_nx)
    );

    vpfp_pack #(.WORD_W(WORD_W), .RES_WORDS(RES_WORDS), .TOT_W(TOT_W)) u_pack (
        .acc   (acc),
        .n_tot (n_tot),
        .sig   (r_sig)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = cls_special ? S_DONE : S_MULT;
            S_MULT: if (last_a && last_b) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs decoded from state
    always_comb begin
        busy = (state != S_IDLE);
        done = (state == S_DONE);
    end

    // Datapath: capture and word-serial accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_sign    <= 1'b0;
            r_type    <= 2'd0;
            r_len     <= '0;
            r_len_ovf <= 1'b0;
            r_exp     <= '0;
            acc       <= '0;
            na_q      <= CNT_W'(1);
            nb_q      <= CNT_W'(1);
            ia        <= '0;
            jb        <= '0;
            for (int i = 0; i < MAX_WORDS; i++) begin
                a_mem[i] <= '0;
                b_mem[i] <= '0;
            end
        end else if (accept) begin
            r_sign    <= a_sign ^ b_sign;
            r_type    <= cls_res;
            r_len_ovf <= len_sum[LEN_W];
            r_len     <= len_sum[LEN_W] ? '1 : len_sum[LEN_W-1:0];
            r_exp     <= a_exp + b_exp;
            acc       <= '0;
            na_q      <= eff_a;
            nb_q      <= eff_b;
            ia        <= '0;
            jb        <= '0;
            for (int i = 0; i < MAX_WORDS; i++) begin
                a_mem[i] <= a_ld[i];
                b_mem[i] <= b_ld[i];
            end
        end else if (state == S_MULT) begin
            acc <= acc_nx;
            if (last_a) begin
                ia <= '0;
                jb <= jb + IDX_W'(1);
            end else begin
                ia <= ia + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/vpfp_mul_chk.sv
module vpfp_mul_chk #(
    parameter int LEN_W = 5,
    parameter int SIG_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             r_sign,
    input logic [1:0]       r_type,
    input logic [LEN_W-1:0] r_len,
    input logic             r_len_ovf,
    input logic [15:0]      r_exp,
    input logic [SIG_W-1:0] r_sig
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_len) && $stable(r_exp) && $stable(r_sign) && $stable(r_type)));

    // R3
    len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_len_ovf |-> (r_len == '1));

    // R7
    special_zero_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_type != 2'd0) |-> (r_sig == '0));
endmodule

bind vpfp_mul vpfp_mul_chk #(.LEN_W(LEN_W), .SIG_W(2*MAX_WORDS*WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .r_sign    (r_sign),
    .r_type    (r_type),
    .r_len     (r_len),
    .r_len_ovf (r_len_ovf),
    .r_exp     (r_exp),
    .r_sig     (r_sig)
);

// File: tb/tb_vpfp_mul.sv
module tb_vpfp_mul;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         a_sign = 1'b0, b_sign = 1'b0;
    logic [1:0]   a_type = '0, b_type = '0;
    logic [4:0]   a_len = '0, b_len = '0;
    logic [15:0]  a_exp = '0, b_exp = '0;
    logic [63:0]  a_sig = '0, b_sig = '0;
    logic         busy, done, r_sign, r_len_ovf;
    logic [1:0]   r_type;
    logic [4:0]   r_len;
    logic [15:0]  r_exp;
    logic [127:0] r_sig;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    vpfp_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_sign(a_sign), .a_type(a_type), .a_len(a_len), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_type(b_type), .b_len(b_len), .b_exp(b_exp), .b_sig(b_sig),
        .busy(busy), .done(done), .r_sign(r_sign), .r_type(r_type), .r_len(r_len),
        .r_len_ovf(r_len_ovf), .r_exp(r_exp), .r_sig(r_sig)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int eff(input logic [4:0] l);
        if (l == 0) return 1;
        if (l > 8) return 8;
        return int'(l);
    endfunction

    function automatic logic [1:0] ref_cls(input logic [1:0] ta, input logic [1:0] tb);
        if (ta == 3 || tb == 3) return 2'd3;
        if ((ta == 2 && tb == 1) || (ta == 1 && tb == 2)) return 2'd3;
        if (ta == 2 || tb == 2) return 2'd2;
        if (ta == 1 || tb == 1) return 2'd1;
        return 2'd0;
    endfunction

    task automatic run_op(input logic sa, input logic [1:0] ta, input logic [4:0] la,
                          input logic [15:0] ea, input logic [63:0] xa,
                          input logic sb, input logic [1:0] tb, input logic [4:0] lb,
                          input logic [15:0] eb, input logic [63:0] xb,
                          input bit inject, input string tag);
        int na, nb, lat, sum;
        logic [1:0]   ecls;
        logic [127:0] va, vb, prod, esig;
        logic [4:0]   elen;
        logic         eovf;
        na = eff(la);
        nb = eff(lb);
        ecls = ref_cls(ta, tb);
        va = '0;
        vb = '0;
        for (int k = 0; k < na; k++) va = (va << 8) | 128'(xa[k*8 +: 8]);
        for (int k = 0; k < nb; k++) vb = (vb << 8) | 128'(xb[k*8 +: 8]);
        prod = va * vb;
        esig = '0;
        if (ecls == 2'd0)
            for (int k = 0; k < na + nb; k++)
                esig[k*8 +: 8] = prod[(na + nb - 1 - k)*8 +: 8];
        sum  = int'(la) + int'(lb);
        eovf = (sum > 31);
        elen = eovf ? 5'd31 : 5'(sum);
        lat  = (ecls == 2'd0) ? na * nb + 1 : 1;

        @(negedge clk);
        a_sign = sa; a_type = ta; a_len = la; a_exp = ea; a_sig = xa;
        b_sign = sb; b_type = tb; b_len = lb; b_exp = eb; b_sig = xb;
        start = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (inject && k == 2) begin
                a_exp = ea + 16'h1234; a_len = la + 5'd3; a_sign = ~sa;
                start = 1'b1;
            end
            if (inject && k == 3) start = 1'b0;
            chk(busy == 1'b1, "R8", {tag, " busy"}, 128'(busy), 128'(1));
            chk(done == (k == lat), "R6", {tag, " done timing"}, 128'(done), 128'(k == lat));
            if (k == lat) begin
                chk(r_sign == (sa ^ sb), "R1", {tag, " sign"}, 128'(r_sign), 128'(sa ^ sb));
                chk(r_exp == 16'(ea + eb), "R2", {tag, " exp"}, 128'(r_exp), 128'(16'(ea + eb)));
                chk(r_len == elen, "R3", {tag, " len"}, 128'(r_len), 128'(elen));
                chk(r_len_ovf == eovf, "R3", {tag, " len ovf"}, 128'(r_len_ovf), 128'(eovf));
                chk(r_type == ecls, "R4", {tag, " class"}, 128'(r_type), 128'(ecls));
                chk(r_sig == esig, (ecls == 0) ? "R5" : "R7", {tag, " sig"}, r_sig, esig);
            end
        end
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8", {tag, " idle after"}, 128'({busy, done}), 128'(0));
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R8", "reset idle", 128'({busy, done}), 128'(0));
        chk(r_sig == '0 && r_len == 0, "R5", "reset result", r_sig, 128'(0));

        // R5 R6 single word each
        run_op(0, 0, 1, 16'h0010, 64'hFF, 1, 0, 1, 16'h0003, 64'hFF, 0, "1x1");
        // R5 full width, all ones for long carry chains
        run_op(1, 0, 8, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 8, 16'hFFFF,
               64'hFFFF_FFFF_FFFF_FFFF, 0, "8x8 ones");
        // R10 unused words carry garbage
        run_op(0, 0, 3, 16'h7FFF, 64'hDEAD_BEEF_DD12_3456, 0, 0, 5, 16'h0001,
               64'hAAAA_AA98_7654_3210, 0, "3x5 garbage");
        // R4 R7 special classes
        run_op(0, 3, 2, 16'h0004, 64'h1234, 1, 0, 2, 16'h0005, 64'h5678, 0, "nan x norm");
        run_op(1, 2, 1, 16'h0100, 64'h01, 0, 1, 1, 16'h0200, 64'h00, 0, "inf x zero");
        run_op(0, 1, 1, 16'h0001, 64'h00, 0, 2, 1, 16'h0002, 64'h01, 0, "zero x inf");
        run_op(1, 2, 4, 16'h8000, 64'h11, 0, 0, 2, 16'h8000, 64'h22, 0, "inf x norm");
        run_op(0, 0, 2, 16'h0011, 64'h3344, 1, 1, 2, 16'h0022, 64'h5566, 0, "norm x zero");
        // R3 boundary 31 and overflow; R9 clamp above 8
        run_op(0, 0, 16, 16'h0000, 64'h0102_0304_0506_0708, 0, 0, 15, 16'h0000,
               64'h1112_1314_1516_1718, 0, "len 31");
        run_op(0, 0, 20, 16'h0000, 64'h8877_6655_4433_2211, 0, 0, 12, 16'h0000,
               64'h0F0E_0D0C_0B0A_0908, 0, "len ovf");
        // R9 length zero uses one word
        run_op(1, 0, 0, 16'hFFF0, 64'h9999_0000_0000_00C3, 1, 0, 2, 16'h0020, 64'hFF_FF, 0, "len0");
        // R8 start while busy has no effect
        run_op(1, 0, 4, 16'h1000, 64'h0A0B_0C0D, 0, 0, 3, 16'h2000, 64'h0E_0F10, 1, "inject");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule